// File: doc/BRIEF.md
# UART Receive and Transmit FIFO Pair with Trigger Levels

This block holds the byte queues of one UART channel: a 64-entry receive FIFO, filled from the serial side and drained by the host, and a 64-entry transmit FIFO, filled by the host and drained by the serial side. A one-byte setup word, written with a single strobe, turns queueing on or off, empties either queue, and selects the receive and transmit trigger levels. With queueing off, each direction holds a single byte.

The block raises two interrupt requests. The receive request is high while the receive fill reaches its trigger level, or after the receive queue has sat idle and non-empty for a set number of character times. The transmit request is high while the free space in the transmit queue reaches its trigger level. After reset the transmit level is 8 spaces. A different transmit level chosen in the setup word is kept in storage but is only used while the `txLevelUnlock` input is high.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset both fill counts are 0, both overrun flags are 0, both pop data outputs are 0, queueing is off, `rxIrq` is 0 and `txIrq` is 1.
- R2: With setup bit 0 set, each direction stores up to 64 bytes and returns them in the order they were pushed, and the fill count gives the number of bytes stored.
- R3: With setup bit 0 clear, each direction holds at most one byte. `rxIrq` is then high when a byte is held, and `txIrq` is high when the transmit holder is empty.
- R4: A push to a full queue is dropped, leaves the count unchanged, and sets that direction's overrun flag. The flag stays set until that direction is flushed.
- R5: A pop from an empty queue leaves both the pop data output and the count unchanged.
- R6: A setup write with bit 1 set empties the receive queue, and one with bit 2 set empties the transmit queue. A flush clears that direction's overrun flag and leaves the other direction untouched. Bits 1 and 2 are not stored. A write that changes bit 0 empties both queues. Pushes and pops in the same cycle as a flush of their direction are ignored.
- R7: In queueing mode `rxIrq` is high while the receive count is at least the level picked by setup bits 7:6: 00 gives 8, 01 gives 16, 10 gives 56 and 11 gives 60.
- R8: In queueing mode `txIrq` is high while the free transmit space (64 minus the count) is at least the transmit level. While `txLevelUnlock` is 0 the level is 8. While it is 1, setup bits 5:4 pick the level: 00 gives 8, 01 gives 16, 10 gives 32 and 11 gives 56.
- R9: In queueing mode, when the receive queue is non-empty and 4 cycles with `charTick` high pass with no receive push or pop, `rxIrq` goes high. Any receive push or pop, or an empty queue, restarts the count.
- R10: A push and a pop in the same cycle on a full queue are both accepted: the oldest byte is popped and the count stays at 64.
- R11: Counts, overrun flags and pop data change on the clock edge that samples the strobe. The interrupt requests follow the stored state, the setup levels and `txLevelUnlock` without further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrite | input | 1 | Setup byte write strobe |
| cfgData | input | 8 | Setup byte: [0] queueing on, [1] flush receive, [2] flush transmit, [5:4] transmit level, [7:6] receive level |
| txLevelUnlock | input | 1 | Applies the stored transmit level when high |
| charTick | input | 1 | One-cycle pulse per character time |
| rxPush | input | 1 | Serial side writes a received byte |
| rxPushData | input | 8 | Received byte |
| rxPop | input | 1 | Host reads a received byte |
| rxPopData | output | 8 | Last byte popped from the receive queue |
| rxCount | output | 7 | Receive fill count |
| rxOverrun | output | 1 | Receive push dropped since the last receive flush |
| rxIrq | output | 1 | Receive data ready request |
| txPush | input | 1 | Host writes a byte to send |
| txPushData | input | 8 | Byte to send |
| txPop | input | 1 | Serial side takes the next byte |
| txPopData | output | 8 | Last byte popped from the transmit queue |
| txCount | output | 7 | Transmit fill count |
| txOverrun | output | 1 | Transmit push dropped since the last transmit flush |
| txIrq | output | 1 | Transmit space request |

## Verification
Every strobe is sampled by one clock edge, and counts, overrun flags and pop data show the result right after that edge. The two interrupt requests are combinational on that state, so they are due in the same cycle as the count they depend on, and they follow a change of `txLevelUnlock` with no delay. The bench changes inputs on the falling edge, keeps each strobe high across exactly one rising edge, and reads every output at the next falling edge, one rising edge after the stimulus. The time-out is checked by counting single `charTick` pulses one at a time, with an idle cycle between them.

// File: rtl/uart_fifo_pkg.sv
`timescale 1ns/1ps
package uart_fifo_pkg;
  localparam int DEPTH   = 64;
  localparam int DATA_W  = 8;
  localparam int PTR_W   = $clog2(DEPTH);
  localparam int CNT_W   = PTR_W + 1;
  localparam int NUM_DIR = 2;
  localparam int DIR_RX  = 0;
  localparam int DIR_TX  = 1;

  // strobes the control hands to one direction's storage
  typedef struct packed {
    logic             wrEn;
    logic             rdEn;
    logic [PTR_W-1:0] wrPtr;
    logic [PTR_W-1:0] rdPtr;
  } fifoStrobe_t;

  function automatic logic [CNT_W-1:0] rxLevel(input logic [1:0] sel);
    case (sel)
      2'b00:   return CNT_W'(8);
      2'b01:   return CNT_W'(16);
      2'b10:   return CNT_W'(DEPTH - 8);
      default: return CNT_W'(DEPTH - 4);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] txLevel(input logic [1:0] sel);
    case (sel)
      2'b00:   return CNT_W'(8);
      2'b01:   return CNT_W'(16);
      2'b10:   return CNT_W'(DEPTH / 2);
      default: return CNT_W'(DEPTH - 8);
    endcase
  endfunction
endpackage

// File: rtl/uart_fifo_store.sv
`timescale 1ns/1ps
module uart_fifo_store
  import uart_fifo_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       stb,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] popData
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (stb.wrEn) mem[stb.wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          popData <= '0;
    else if (stb.rdEn)  popData <= mem[stb.rdPtr];
  end
endmodule

// File: rtl/uart_fifo_ctrl.sv
`timescale 1ns/1ps
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int TIMEOUT_CHARS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrite,
  input  logic [7:0]       cfgData,
  input  logic             txLevelUnlock,
  input  logic             charTick,
  input  logic             rxPush,
  input  logic             rxPop,
  input  logic             txPush,
  input  logic             txPop,
  output fifoStrobe_t      rxStb,
  output fifoStrobe_t      txStb,
  output logic [CNT_W-1:0] rxCount,
  output logic [CNT_W-1:0] txCount,
  output logic             rxOverrun,
  output logic             txOverrun,
  output logic             rxIrq,
  output logic             txIrq,
  output logic             fifoEn
);
  localparam int TO_W = $clog2(TIMEOUT_CHARS + 1);

  logic                 fifoEnQ;
  logic [1:0]           rxSelQ;
  logic [1:0]           txSelQ;
  logic [NUM_DIR-1:0]   pushReq, popReq, flushReq, pushOk, popOk, ovrQ;
  logic [CNT_W-1:0]     cntQ   [NUM_DIR];
  logic [PTR_W-1:0]     wrPtrQ [NUM_DIR];
  logic [PTR_W-1:0]     rdPtrQ [NUM_DIR];
  fifoStrobe_t          stb    [NUM_DIR];
  logic [CNT_W-1:0]     capacity;
  logic [TO_W-1:0]      idleTicksQ;
  logic                 idleHit;
  logic [CNT_W-1:0]     rxTrig, txTrig, txSpace;

  assign pushReq  = {txPush, rxPush};
  assign popReq   = {txPop, rxPop};
  assign capacity = fifoEnQ ? CNT_W'(DEPTH) : CNT_W'(1);

  // stored part of the setup byte; flush bits are never kept
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoEnQ <= 1'b0;
      rxSelQ  <= 2'b00;
      txSelQ  <= 2'b00;
    end else if (cfgWrite) begin
      fifoEnQ <= cfgData[0];
      rxSelQ  <= cfgData[7:6];
      txSelQ  <= cfgData[5:4];
    end
  end

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    assign flushReq[d] = cfgWrite && (cfgData[1+d] || (cfgData[0] != fifoEnQ));
    assign popOk[d]    = popReq[d] && (cntQ[d] != '0) && !flushReq[d];
    assign pushOk[d]   = pushReq[d] && !flushReq[d] &&
                         ((cntQ[d] < capacity) || popOk[d]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ[d]   <= '0;
        wrPtrQ[d] <= '0;
        rdPtrQ[d] <= '0;
        ovrQ[d]   <= 1'b0;
      end else if (flushReq[d]) begin
        cntQ[d]   <= '0;
        wrPtrQ[d] <= '0;
        rdPtrQ[d] <= '0;
        ovrQ[d]   <= 1'b0;
      end else begin
        if (pushOk[d]) wrPtrQ[d] <= wrPtrQ[d] + 1'b1;
        if (popOk[d])  rdPtrQ[d] <= rdPtrQ[d] + 1'b1;
        if (pushOk[d] && !popOk[d])      cntQ[d] <= cntQ[d] + 1'b1;
        else if (!pushOk[d] && popOk[d]) cntQ[d] <= cntQ[d] - 1'b1;
        if (pushReq[d] && !pushOk[d])    ovrQ[d] <= 1'b1;
      end
    end

    assign stb[d] = '{wrEn: pushOk[d], rdEn: popOk[d],
                      wrPtr: wrPtrQ[d], rdPtr: rdPtrQ[d]};
  end

  // receive idle counter in character times
  assign idleHit = (idleTicksQ == TO_W'(TIMEOUT_CHARS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      idleTicksQ <= '0;
    else if (!fifoEnQ || (cntQ[DIR_RX] == '0) || rxPush || rxPop || flushReq[DIR_RX])
      idleTicksQ <= '0;
    else if (charTick && !idleHit)
      idleTicksQ <= idleTicksQ + 1'b1;
  end

  assign rxTrig  = fifoEnQ ? rxLevel(rxSelQ) : CNT_W'(1);
  assign txTrig  = txLevelUnlock ? txLevel(txSelQ) : txLevel(2'b00);
  assign txSpace = CNT_W'(DEPTH) - cntQ[DIR_TX];

  assign rxIrq     = (cntQ[DIR_RX] >= rxTrig) || idleHit;
  assign txIrq     = fifoEnQ ? (txSpace >= txTrig) : (cntQ[DIR_TX] == '0);
  assign rxStb     = stb[DIR_RX];
  assign txStb     = stb[DIR_TX];
  assign rxCount   = cntQ[DIR_RX];
  assign txCount   = cntQ[DIR_TX];
  assign rxOverrun = ovrQ[DIR_RX];
  assign txOverrun = ovrQ[DIR_TX];
  assign fifoEn    = fifoEnQ;
endmodule

// File: rtl/uart_fifo_pair.sv
`timescale 1ns/1ps
module uart_fifo_pair
  import uart_fifo_pkg::*;
#(
  parameter int TIMEOUT_CHARS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic [7:0]        cfgData,
  input  logic              txLevelUnlock,
  input  logic              charTick,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxPushData,
  input  logic              rxPop,
  output logic [DATA_W-1:0] rxPopData,
  output logic [CNT_W-1:0]  rxCount,
  output logic              rxOverrun,
  output logic              rxIrq,
  input  logic              txPush,
  input  logic [DATA_W-1:0] txPushData,
  input  logic              txPop,
  output logic [DATA_W-1:0] txPopData,
  output logic [CNT_W-1:0]  txCount,
  output logic              txOverrun,
  output logic              txIrq
);
  fifoStrobe_t rxStb, txStb;
  logic        fifoEn;

  uart_fifo_ctrl #(.TIMEOUT_CHARS(TIMEOUT_CHARS)) ctrl (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgData(cfgData),
    .txLevelUnlock(txLevelUnlock), .charTick(charTick),
    .rxPush(rxPush), .rxPop(rxPop), .txPush(txPush), .txPop(txPop),
    .rxStb(rxStb), .txStb(txStb), .rxCount(rxCount), .txCount(txCount),
    .rxOverrun(rxOverrun), .txOverrun(txOverrun),
    .rxIrq(rxIrq), .txIrq(txIrq), .fifoEn(fifoEn)
  );

  uart_fifo_store rxStore (
    .clk(clk), .rstN(rstN), .stb(rxStb), .pushData(rxPushData), .popData(rxPopData)
  );

  uart_fifo_store txStore (
    .clk(clk), .rstN(rstN), .stb(txStb), .pushData(txPushData), .popData(txPopData)
  );
endmodule

// File: rtl/uart_fifo_pair_chk.sv
`timescale 1ns/1ps
module uart_fifo_pair_chk
  import uart_fifo_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrite,
  input logic [7:0]        cfgData,
  input logic              txLevelUnlock,
  input logic              rxPush,
  input logic              rxPop,
  input logic [DATA_W-1:0] rxPopData,
  input logic [CNT_W-1:0]  rxCount,
  input logic              rxOverrun,
  input logic              rxIrq,
  input logic [CNT_W-1:0]  txCount,
  input logic              txIrq,
  input logic              fifoEn
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrite |=> (rxCount == $past(rxCount) || rxCount == $past(rxCount) + 1'b1 ||
                   rxCount + 1'b1 == $past(rxCount))); // R2
  AST_HOLD_CAP: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEn |-> (rxCount <= CNT_W'(1) && txCount <= CNT_W'(1))); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && !rxPop && !cfgWrite && rxCount == CNT_W'(DEPTH))
      |=> (rxOverrun && rxCount == CNT_W'(DEPTH))); // R4
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rstN)
    (rxPop && !rxPush && !cfgWrite && rxCount == '0)
      |=> ($stable(rxPopData) && rxCount == '0)); // R5
  AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && cfgData[1]) |=> (rxCount == '0 && !rxOverrun)); // R6
  AST_RX_TOP_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && rxCount >= CNT_W'(DEPTH - 4)) |-> rxIrq); // R7
  AST_TX_LOCKED_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && !txLevelUnlock && txCount > CNT_W'(DEPTH - 8)) |-> !txIrq); // R8
  AST_FULL_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && rxPop && !cfgWrite && rxCount == CNT_W'(DEPTH))
      |=> rxCount == CNT_W'(DEPTH)); // R10
endmodule

bind uart_fifo_pair uart_fifo_pair_chk chk (
  .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgData(cfgData),
  .txLevelUnlock(txLevelUnlock), .rxPush(rxPush), .rxPop(rxPop),
  .rxPopData(rxPopData), .rxCount(rxCount), .rxOverrun(rxOverrun),
  .rxIrq(rxIrq), .txCount(txCount), .txIrq(txIrq), .fifoEn(fifoEn)
);

// File: tb/uart_fifo_pair_test.sv
`timescale 1ns/1ps
module uart_fifo_pair_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrite = 1'b0;
  logic [7:0] cfgData = 8'h00;
  logic       txLevelUnlock = 1'b0;
  logic       charTick = 1'b0;
  logic       rxPush = 1'b0, rxPop = 1'b0, txPush = 1'b0, txPop = 1'b0;
  logic [7:0] rxPushData = 8'h00, txPushData = 8'h00;
  logic [7:0] rxPopData, txPopData;
  logic [6:0] rxCount, txCount;
  logic       rxOverrun, txOverrun, rxIrq, txIrq;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  uart_fifo_pair uut (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgData(cfgData),
    .txLevelUnlock(txLevelUnlock), .charTick(charTick),
    .rxPush(rxPush), .rxPushData(rxPushData), .rxPop(rxPop),
    .rxPopData(rxPopData), .rxCount(rxCount), .rxOverrun(rxOverrun), .rxIrq(rxIrq),
    .txPush(txPush), .txPushData(txPushData), .txPop(txPop),
    .txPopData(txPopData), .txCount(txCount), .txOverrun(txOverrun), .txIrq(txIrq)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic       push;
    logic       pop;
    logic [7:0] din;
    logic [6:0] expCnt;
    logic [7:0] expOut;
  } vec_t;

  // receive path in queueing mode; output starts at A1 from the holding test
  localparam vec_t VECS [9] = '{
    '{1'b1, 1'b0, 8'h10, 7'd1, 8'hA1},
    '{1'b1, 1'b0, 8'h20, 7'd2, 8'hA1},
    '{1'b1, 1'b0, 8'h30, 7'd3, 8'hA1},
    '{1'b0, 1'b1, 8'h00, 7'd2, 8'h10},
    '{1'b1, 1'b0, 8'h40, 7'd3, 8'h10},
    '{1'b0, 1'b1, 8'h00, 7'd2, 8'h20},
    '{1'b0, 1'b1, 8'h00, 7'd1, 8'h30},
    '{1'b0, 1'b1, 8'h00, 7'd0, 8'h40},
    '{1'b0, 1'b1, 8'h00, 7'd0, 8'h40}
  };

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfgT(input logic [7:0] v);
    @(negedge clk); cfgWrite = 1'b1; cfgData = v;
    @(negedge clk); cfgWrite = 1'b0;
  endtask
  task automatic rxPushT(input logic [7:0] d);
    @(negedge clk); rxPush = 1'b1; rxPushData = d;
    @(negedge clk); rxPush = 1'b0;
  endtask
  task automatic rxPopT();
    @(negedge clk); rxPop = 1'b1;
    @(negedge clk); rxPop = 1'b0;
  endtask
  task automatic rxBothT(input logic [7:0] d);
    @(negedge clk); rxPush = 1'b1; rxPop = 1'b1; rxPushData = d;
    @(negedge clk); rxPush = 1'b0; rxPop = 1'b0;
  endtask
  task automatic txPushT(input logic [7:0] d);
    @(negedge clk); txPush = 1'b1; txPushData = d;
    @(negedge clk); txPush = 1'b0;
  endtask
  task automatic txPopT();
    @(negedge clk); txPop = 1'b1;
    @(negedge clk); txPop = 1'b0;
  endtask
  task automatic tickT();
    @(negedge clk); charTick = 1'b1;
    @(negedge clk); charTick = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nFails++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 rxCount", rxCount, 0);
    chk("R1 txCount", txCount, 0);
    chk("R1 rxIrq", rxIrq, 0);
    chk("R1 txIrq", txIrq, 1);
    chk("R1 rxPopData", rxPopData, 0);
    chk("R1 overrun", {rxOverrun, txOverrun}, 0);

    // R3 holding mode, R4 drop, R5 empty pop
    rxPushT(8'hA1);
    chk("R3 holding count", rxCount, 1);
    chk("R3 holding rxIrq", rxIrq, 1);
    rxPushT(8'hB2);
    chk("R3 holding capacity", rxCount, 1);
    chk("R4 holding overrun", rxOverrun, 1);
    rxPopT();
    chk("R3 holding data", rxPopData, 8'hA1);
    chk("R3 holding empty", rxCount, 0);
    rxPopT();
    chk("R5 empty pop data", rxPopData, 8'hA1);
    chk("R5 empty pop count", rxCount, 0);

    // R6 mode change empties both and clears overrun
    cfgT(8'h01);
    chk("R6 mode change overrun", rxOverrun, 0);

    // R2 ordering walk
    foreach (VECS[i]) begin
      @(negedge clk); rxPush = VECS[i].push; rxPop = VECS[i].pop; rxPushData = VECS[i].din;
      @(negedge clk); rxPush = 1'b0; rxPop = 1'b0;
      chk($sformatf("R2 vec%0d count", i), rxCount, VECS[i].expCnt);
      chk($sformatf("R2 vec%0d data", i), rxPopData, VECS[i].expOut);
    end

    // R7 receive levels
    rxPushT(8'h40);
    for (int i = 0; i < 6; i++) rxPushT(8'h41);
    chk("R7 level8 below", rxIrq, 0);
    rxPushT(8'h41);
    chk("R7 level8 reached", rxIrq, 1);
    cfgT(8'h41);
    chk("R7 level16 below", rxIrq, 0);
    for (int i = 0; i < 8; i++) rxPushT(8'h41);
    chk("R7 level16 reached", rxIrq, 1);
    cfgT(8'h81);
    chk("R7 level56 below", rxIrq, 0);
    cfgT(8'hC1);
    for (int i = 0; i < 43; i++) rxPushT(8'h41);
    chk("R7 level60 below count", rxCount, 59);
    chk("R7 level60 below", rxIrq, 0);
    rxPushT(8'h41);
    chk("R7 level60 reached", rxIrq, 1);
    for (int i = 0; i < 4; i++) rxPushT(8'h41);
    chk("R2 full count", rxCount, 64);
    chk("R4 no overrun yet", rxOverrun, 0);
    rxPushT(8'h42);
    chk("R4 full drop count", rxCount, 64);
    chk("R4 full drop overrun", rxOverrun, 1);
    rxBothT(8'hEE);
    chk("R10 push pop full count", rxCount, 64);
    chk("R10 push pop full data", rxPopData, 8'h40);
    chk("R4 overrun sticky", rxOverrun, 1);

    for (int i = 0; i < 3; i++) txPushT(8'h80 + 8'(i));
    cfgT(8'h03);
    chk("R6 rx flush count", rxCount, 0);
    chk("R6 rx flush overrun", rxOverrun, 0);
    chk("R6 tx untouched", txCount, 3);

    // R8 transmit levels
    for (int i = 0; i < 54; i++) txPushT(8'h90);
    chk("R8 count57", txCount, 57);
    chk("R8 locked space7", txIrq, 0);
    txPopT();
    chk("R2 tx order", txPopData, 8'h80);
    chk("R8 locked space8", txIrq, 1);
    cfgT(8'h31);
    chk("R8 stored not applied", txIrq, 1);
    @(negedge clk); txLevelUnlock = 1'b1;
    @(negedge clk);
    chk("R8 unlock level56", txIrq, 0);
    cfgT(8'h21);
    chk("R8 level32 space8", txIrq, 0);
    cfgT(8'h11);
    chk("R8 level16 space8", txIrq, 0);
    for (int i = 0; i < 8; i++) txPopT();
    chk("R8 level16 space16", txIrq, 1);
    cfgT(8'h21);
    chk("R8 level32 space16", txIrq, 0);
    for (int i = 0; i < 16; i++) txPopT();
    chk("R8 level32 space32", txIrq, 1);
    cfgT(8'h31);
    chk("R8 level56 space32", txIrq, 0);
    for (int i = 0; i < 24; i++) txPopT();
    chk("R8 level56 space56", txIrq, 1);
    @(negedge clk); txLevelUnlock = 1'b0;

    // R9 receive time-out
    cfgT(8'h03);
    rxPushT(8'h51);
    rxPushT(8'h52);
    for (int i = 0; i < 3; i++) tickT();
    chk("R9 three ticks", rxIrq, 0);
    rxPushT(8'h53);
    for (int i = 0; i < 3; i++) tickT();
    chk("R9 push restarts", rxIrq, 0);
    tickT();
    chk("R9 timeout fires", rxIrq, 1);
    rxPopT();
    chk("R9 pop data", rxPopData, 8'h51);
    chk("R9 pop clears", rxIrq, 0);
    for (int i = 0; i < 4; i++) tickT();
    chk("R9 fires again", rxIrq, 1);
    rxPopT();
    rxPopT();
    for (int i = 0; i < 4; i++) tickT();
    chk("R9 empty no timeout", rxIrq, 0);

    // R3 transmit holding mode
    cfgT(8'h00);
    chk("R6 mode change tx count", txCount, 0);
    chk("R3 tx holder empty irq", txIrq, 1);
    txPushT(8'h55);
    chk("R3 tx holder full irq", txIrq, 0);
    txPushT(8'h66);
    chk("R4 tx overrun", txOverrun, 1);
    chk("R3 tx capacity", txCount, 1);
    txPopT();
    chk("R3 tx holder data", txPopData, 8'h55);
    chk("R11 tx irq after pop", txIrq, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule